// File: doc/BRIEF.md
# Bit-Serial Block SAD Engine

This block scores how well a candidate pixel block matches a reference block. It takes N×N pixel pairs, each pair on its own pair of one-bit wires, and returns the unnormalised sum of absolute differences over the block. Every operand is an unsigned 8-bit pixel that is sent least significant bit first. The operand is padded with zeros to a word of W = 8 + ceil(log2(N×N)) bits, so the sum cannot overflow. Each lane has a one-bit subtracter. It is followed by a one-word delay line that turns the signed difference into a magnitude. A tree of one-bit full adders reduces all lanes to one serial word, which is then gathered into a parallel result.

Words arrive back to back, one every W clocks, with no gaps. A strobe on `frame_i` marks bit 0 of a word. After the first strobe the block keeps the cadence itself, so later strobes are optional. A strobe that lands off the cadence restarts the alignment and throws away every word still in flight. Results leave as a parallel word with a one-cycle valid pulse. The output has no ready signal, because the serial lanes cannot be held still. The consumer must take `sad_o` in the pulse cycle, or later, since `sad_o` holds its value until the next pulse. Pixel storage, search ordering and division by the pixel count are outside this block.

Top module: `sad_bitserial_top`

## Requirements
- R1: While reset is asserted and after it is released, `sad_valid_o` is low and `sad_o` is zero until the first result.
- R2: Each result equals the sum over all N×N lanes of |ref − cand|. Operand bit j of an 8-bit pixel is driven in phase j of its word, where phase 0 is the strobe cycle.
- R3: A word is W = 8 + ceil(log2(N×N)) cycles long. Consecutive words follow without gaps and each yields one result.
- R4: The result for a word whose phase 0 is cycle t appears with its valid pulse in cycle t + LATENCY, where LATENCY = 2·W + ceil(log2(N×N)).
- R5: `sad_valid_o` is high for exactly one cycle per completed word, and two pulses are at least W cycles apart.
- R6: Input bits in phases 8 to W−1 are ignored. Operands are treated as zero-extended whatever those bits carry.
- R7: No result is produced before the first strobe. After it, words keep being scored every W cycles with or without further strobes.
- R8: A strobe that does not fall in phase 0 of the running cadence discards all words in flight. No pulse appears until the new word's result at strobe + LATENCY.
- R9: `sad_o` changes only in a cycle where `sad_valid_o` is high.
- R10: Extreme operands are scored without overflow, in both directions (ref 255 / cand 0 and ref 0 / cand 255). The largest result is N×N·255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Marks phase 0 (bit 0) of a word |
| ref_bits_i | input | N×N | One serial reference bit per lane, LSB first |
| cand_bits_i | input | N×N | One serial candidate bit per lane, LSB first |
| sad_o | output | W | Sum of absolute differences of the last scored word |
| sad_valid_o | output | 1 | One-cycle pulse when `sad_o` carries a new result |

## Verification
The bench builds the block with N = 3. That gives nine lanes, a 12-bit word and a four-level adder tree. Nine is not a power of two, so seven padded zero leaves take part in every sum, and the result latency of 28 cycles spans more than two words. With only 12 phases per word, the ignored padding bits, the free-running cadence and a strobe dropped into phase 5 all come up within a few hundred cycles. The bench also runs saturated operands in both directions.

// File: rtl/sad_pkg.sv
package sad_pkg;

  // Adder-tree depth, which is also the number of extra bits the sum needs.
  function automatic int sad_depth(input int n);
    return $clog2(n * n);
  endfunction

  // Word length carried by every serial path.
  function automatic int sad_width(input int n, input int pix_w);
    return pix_w + sad_depth(n);
  endfunction

  // Cycles from phase 0 of an input word to its result pulse:
  // one word in the difference delay line, one word of shifting out,
  // one register per tree level.
  function automatic int sad_latency(input int n, input int pix_w);
    return 2 * sad_width(n, pix_w) + sad_depth(n);
  endfunction

endpackage

// File: rtl/sad_phase_ctrl.sv
module sad_phase_ctrl #(
  parameter int W     = 14,
  parameter int D     = 6,
  parameter int PIX_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_i,
  output logic [D-1:0] phase_hit_o,
  output logic         pix_en_o,
  output logic         load_o
);
  localparam int PHW = $clog2(W);

  logic [PHW-1:0] ph_q;
  logic [PHW-1:0] ph;
  logic           wrap;
  logic           run_q;
  logic           misalign;
  logic           tok_in_q;
  logic           tok_abs_q;
  logic           tok_tree_q;

  assign wrap     = (ph_q == PHW'(W - 1));
  assign ph       = (frame_i || wrap) ? '0 : ph_q + PHW'(1);
  assign misalign = frame_i && run_q && !wrap;
  assign pix_en_o = (ph < PHW'(PIX_W));

  // Phase decode: level l of the pipeline starts its word in phase l.
  for (genvar l = 0; l < D; l++) begin : g_hit
    assign phase_hit_o[l] = (ph == PHW'(l));
  end

  // The last root bit of a scored word arrives in phase D-1.
  assign load_o = phase_hit_o[D-1] && tok_tree_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PHW'(W - 1);
      run_q      <= 1'b0;
      tok_in_q   <= 1'b0;
      tok_abs_q  <= 1'b0;
      tok_tree_q <= 1'b0;
    end else begin
      ph_q  <= ph;
      run_q <= run_q || frame_i;
      if (misalign) begin
        tok_in_q   <= 1'b1;
        tok_abs_q  <= 1'b0;
        tok_tree_q <= 1'b0;
      end else if (ph == '0) begin
        tok_in_q   <= run_q || frame_i;
        tok_abs_q  <= tok_in_q;
        tok_tree_q <= tok_abs_q;
      end
    end
  end
endmodule

// File: rtl/sad_lane.sv
module sad_lane #(
  parameter int W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic pix_en_i,
  input  logic ref_i,
  input  logic cand_i,
  output logic mag_o
);
  logic         a_bit;
  logic         nb_bit;
  logic         cin;
  logic         diff;
  logic         carry_q;
  logic [W-1:0] dly_q;
  logic         sign_q;
  logic         sign_e;
  logic         seen_q;
  logic         seen_e;

  // ref - cand as ref + ~cand + 1, upper phases forced to zero.
  assign a_bit  = ref_i & pix_en_i;
  assign nb_bit = ~(cand_i & pix_en_i);
  assign cin    = start_i ? 1'b1 : carry_q;
  assign diff   = a_bit ^ nb_bit ^ cin;

  // The delay line's oldest bit is bit 0 of the previous word while
  // its newest holds that word's sign, both present in phase 0.
  assign sign_e = start_i ? dly_q[W-1] : sign_q;
  assign seen_e = start_i ? 1'b0 : seen_q;
  // Serial negation: copy bits up to the first one, invert after it.
  assign mag_o  = dly_q[0] ^ (sign_e & seen_e);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      dly_q   <= '0;
      sign_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      carry_q <= (a_bit & nb_bit) | (a_bit & cin) | (nb_bit & cin);
      dly_q   <= {diff, dly_q[W-1:1]};
      sign_q  <= sign_e;
      seen_q  <= seen_e | dly_q[0];
    end
  end
endmodule

// File: rtl/sad_fa_node.sv
module sad_fa_node (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic x_i,
  input  logic y_i,
  output logic sum_o
);
  logic carry_q;
  logic cin;

  assign cin = clr_i ? 1'b0 : carry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      sum_o   <= 1'b0;
    end else begin
      carry_q <= (x_i & y_i) | (x_i & cin) | (y_i & cin);
      sum_o   <= x_i ^ y_i ^ cin;
    end
  end
endmodule

// File: rtl/sad_bitserial_top.sv
module sad_bitserial_top
  import sad_pkg::*;
#(
  parameter  int N     = 8,
  parameter  int PIX_W = 8,
  localparam int LANES = N * N,
  localparam int W     = sad_width(N, PIX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_i,
  input  logic [LANES-1:0] ref_bits_i,
  input  logic [LANES-1:0] cand_bits_i,
  output logic [W-1:0]     sad_o,
  output logic             sad_valid_o
);
  localparam int D = sad_depth(N);
  localparam int P = 1 << D;

  logic [D-1:0]     hit;
  logic             pix_en;
  logic             load;
  logic [LANES-1:0] mag;
  logic [2*P-1:1]   tree;
  logic [W-1:0]     acc_q;

  sad_phase_ctrl #(.W(W), .D(D), .PIX_W(PIX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_i    (frame_i),
    .phase_hit_o(hit),
    .pix_en_o   (pix_en),
    .load_o     (load)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sad_lane #(.W(W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (hit[0]),
      .pix_en_i(pix_en),
      .ref_i   (ref_bits_i[i]),
      .cand_i  (cand_bits_i[i]),
      .mag_o   (mag[i])
    );
  end

  // Heap-ordered tree: leaves at P..2P-1, padded with zeros.
  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < LANES) begin : g_used
      assign tree[P+i] = mag[i];
    end else begin : g_pad
      assign tree[P+i] = 1'b0;
    end
  end

  for (genvar i = 1; i < P; i++) begin : g_node
    localparam int LVL = D - ($clog2(i + 1) - 1);
    sad_fa_node u_fa (
      .clk  (clk),
      .rst_n(rst_n),
      .clr_i(hit[LVL-1]),
      .x_i  (tree[2*i]),
      .y_i  (tree[2*i+1]),
      .sum_o(tree[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      sad_o       <= '0;
      sad_valid_o <= 1'b0;
    end else begin
      acc_q       <= {tree[1], acc_q[W-1:1]};
      sad_valid_o <= load;
      if (load) begin
        sad_o <= {tree[1], acc_q[W-1:1]};
      end
    end
  end
endmodule

// File: rtl/sad_bitserial_chk.sv
module sad_bitserial_chk
  import sad_pkg::*;
#(
  parameter int N     = 8,
  parameter int PIX_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [sad_width(N,PIX_W)-1:0] sad_o,
  input logic                         sad_valid_o
);
  localparam int W    = sad_width(N, PIX_W);
  localparam int LAT  = sad_latency(N, PIX_W);
  localparam int MAXV = N * N * ((1 << PIX_W) - 1);

  logic [15:0] gap_q;
  logic        seen_q;
  logic [15:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      age_q  <= '0;
    end else begin
      if (age_q != 16'hFFFF) age_q <= age_q + 16'd1;
      if (sad_valid_o) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != 16'hFFFF) begin
        gap_q <= gap_q + 16'd1;
      end
    end
  end

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid_o |=> !sad_valid_o);

  // R5
  valid_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sad_valid_o && seen_q) |-> (gap_q >= 16'(W - 1)));

  // R10
  sad_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid_o |-> (sad_o <= W'(MAXV)));

  // R9
  sad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sad_o) |-> sad_valid_o);

  // R4
  first_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sad_valid_o |-> (age_q >= 16'(LAT)));
endmodule

bind sad_bitserial_top sad_bitserial_chk #(.N(N), .PIX_W(PIX_W)) u_sad_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sad_o      (sad_o),
  .sad_valid_o(sad_valid_o)
);

// File: tb/test_sad_bitserial_top.sv
module test_sad_bitserial_top;
  localparam int N   = 3;
  localparam int PW  = 8;
  localparam int LN  = N * N;
  localparam int DP  = $clog2(LN);
  localparam int W   = PW + DP;
  localparam int LAT = 2 * W + DP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame = 1'b0;
  logic [LN-1:0] rb = '0;
  logic [LN-1:0] cb = '0;
  logic [W-1:0]  sad;
  logic          vld;

  sad_bitserial_top #(.N(N), .PIX_W(PW)) i_sad_bitserial_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_i    (frame),
    .ref_bits_i (rb),
    .cand_bits_i(cb),
    .sad_o      (sad),
    .sad_valid_o(vld)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          checks = 0;
  int          errors = 0;
  string       tag = "R1";
  bit          started = 1'b0;
  bit          junk = 1'b0;
  int          qc[$];
  int          qv[$];
  logic [W-1:0] last_sad = '0;
  logic [7:0]  pa[LN];
  logic [7:0]  pb[LN];
  int unsigned seed = 32'd12345;

  function automatic int unsigned nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp,
                     input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Result monitor: compares each pulse against the expected cycle and value.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n) begin
        while (qc.size() > 0 && qc[0] < cyc) begin
          chk(1'b0, tag, 0, qv[0], "result pulse missing (R4)");
          void'(qc.pop_front());
          void'(qv.pop_front());
        end
        if (vld) begin
          if (qc.size() > 0 && qc[0] == cyc) begin
            chk(sad == W'(qv[0]), tag, int'(sad), qv[0], "sad value (R2)");
            void'(qc.pop_front());
            void'(qv.pop_front());
          end else begin
            chk(1'b0, tag, int'(sad), -1, "unexpected valid pulse (R5)");
          end
          last_sad = sad;
        end else if (sad !== last_sad) begin
          chk(1'b0, "R9", int'(sad), int'(last_sad), "sad_o moved without valid");
        end
      end
    end
  end

  // One full word; strobe drives frame in phase 0, realign drops results in flight.
  task automatic drive_word(input bit strobe, input bit realign);
    int sum;
    sum = 0;
    for (int l = 0; l < LN; l++) begin
      sum += (pa[l] > pb[l]) ? int'(pa[l]) - int'(pb[l]) : int'(pb[l]) - int'(pa[l]);
    end
    for (int j = 0; j < W; j++) begin
      @(negedge clk);
      frame = (j == 0) && strobe;
      for (int l = 0; l < LN; l++) begin
        rb[l] = (j < PW) ? pa[l][j] : (junk ? nxt() % 2 == 1 : 1'b0);
        cb[l] = (j < PW) ? pb[l][j] : (junk ? nxt() % 2 == 1 : 1'b0);
      end
      if (j == 0) begin
        if (realign) begin
          while (qc.size() > 0 && qc[qc.size()-1] >= cyc + 1) begin
            void'(qc.pop_back());
            void'(qv.pop_back());
          end
        end
        if (strobe) started = 1'b1;
        if (started) begin
          qc.push_back(cyc + LAT);
          qv.push_back(sum);
        end
      end
    end
  endtask

  task automatic fill_rand();
    for (int l = 0; l < LN; l++) begin
      pa[l] = 8'(nxt());
      pb[l] = 8'(nxt());
    end
  endtask

  task automatic fill_const(input logic [7:0] a, input logic [7:0] b);
    for (int l = 0; l < LN; l++) begin
      pa[l] = a;
      pb[l] = b;
    end
  endtask

  // Zero words until all results of the scenario have come out.
  task automatic flush_and_close(input string req, input int err0);
    fill_const(8'd0, 8'd0);
    for (int k = 0; k < 4; k++) drive_word(1'b1, 1'b0);
    chk(errors == err0, req, errors - err0, 0, "scenario errors");
  endtask

  task automatic t_reset();
    tag = "R1";
    @(negedge clk);
    chk(vld == 1'b0, "R1", int'(vld), 0, "valid in reset");
    chk(sad == '0, "R1", int'(sad), 0, "sad in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(vld == 1'b0 && sad == '0, "R1", int'(sad), 0, "state after reset");
    tag = "R7";
    fill_rand();
    drive_word(1'b0, 1'b0);
    drive_word(1'b0, 1'b0);
    chk(vld == 1'b0, "R7", int'(vld), 0, "no pulse before first strobe");
  endtask

  task automatic t_equal();
    int e0;
    e0 = errors;
    tag = "R2";
    fill_rand();
    for (int l = 0; l < LN; l++) pb[l] = pa[l];
    drive_word(1'b1, 1'b0);
    flush_and_close("R2", e0);
  endtask

  task automatic t_random();
    int e0;
    e0 = errors;
    tag = "R3";
    for (int k = 0; k < 8; k++) begin
      fill_rand();
      drive_word(1'b1, 1'b0);
    end
    flush_and_close("R3", e0);
  endtask

  task automatic t_extremes();
    int e0;
    e0 = errors;
    tag = "R10";
    fill_const(8'd255, 8'd0);
    drive_word(1'b1, 1'b0);
    fill_const(8'd0, 8'd255);
    drive_word(1'b1, 1'b0);
    for (int l = 0; l < LN; l++) begin
      pa[l] = (l % 2 == 0) ? 8'd255 : 8'd0;
      pb[l] = (l % 2 == 0) ? 8'd0 : 8'd255;
    end
    drive_word(1'b1, 1'b0);
    fill_const(8'd1, 8'd2);
    drive_word(1'b1, 1'b0);
    flush_and_close("R10", e0);
  endtask

  task automatic t_junk();
    int e0;
    e0 = errors;
    tag = "R6";
    junk = 1'b1;
    for (int k = 0; k < 4; k++) begin
      fill_rand();
      drive_word(1'b1, 1'b0);
    end
    junk = 1'b0;
    flush_and_close("R6", e0);
  endtask

  task automatic t_freerun();
    int e0;
    e0 = errors;
    tag = "R7";
    for (int k = 0; k < 5; k++) begin
      fill_rand();
      drive_word(1'b0, 1'b0);
    end
    flush_and_close("R7", e0);
  endtask

  task automatic t_realign();
    int e0;
    e0 = errors;
    tag = "R8";
    fill_rand();
    drive_word(1'b1, 1'b0);
    fill_rand();
    drive_word(1'b1, 1'b0);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      frame = 1'b0;
      rb = LN'(nxt());
      cb = LN'(nxt());
    end
    fill_rand();
    drive_word(1'b1, 1'b1);
    fill_rand();
    drive_word(1'b0, 1'b0);
    flush_and_close("R8", e0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_equal();
    t_random();
    t_extremes();
    t_junk();
    t_freerun();
    t_realign();
    chk(qc.size() <= 3, "R5", qc.size(), 3, "results left pending");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule